// File: doc/BRIEF.md
# SMBus Byte-Data Read Host

This block is an SMBus master that runs one protocol, the byte-data read. Software works through a small register port with single-cycle reads and writes. It stores the slave address and the byte offset, then writes a start word to the control register. It then polls the status register until the busy bit drops and takes the returned byte from the data register. On the wire the block drives two open-drain lines, and each one is either pulled low or released. The data line is read back through a two-stage synchroniser.

Each bus bit is split into four quarter periods, and a free-running divider produces one tick per quarter. The line changes and the sample points are placed on the quarter boundaries. A status bit works as a software semaphore: the first read of the status register claims the host, and a write releases it. The other status flags are cleared by writing a one to them. Writing 0xFE to the status register performs a host reset. It clears every clearable flag and releases ownership.

Top module: `smb_host`

## Requirements
- R1: After reset, the status, control, command, address and data registers all read 0x00, and both bus lines are released.
- R2: Status bit 6 (in use) is an ownership flag. A read of the status register (address 0) with the read strobe set returns the value from before the claim, and then sets bit 6. A peek without the strobe leaves the flag unchanged.
- R3: Writing the status register clears each of bits 1 to 4 that has a one in the written word, and releases ownership when bit 6 is one. Writing 0xFE clears all of these. Writing 0x02 leaves the device-error flag set. The busy bit is not writable.
- R4: A control write (address 1) with bit 6 set and bits 4:2 equal to 010 starts a byte-data read. Status bit 0 (busy) reads 1 from the cycle after that write until the STOP condition has completed.
- R5: The wire sequence is START, then {addr[7:1],0}, then slave ACK. Next comes the command byte (address 2), then ACK. Then a repeated START, then {addr[7:1],1}, then ACK. The slave's 8 data bits follow, then a master NACK (line released), then STOP. All bytes are sent MSB first. Bit 0 of the address register (address 3) is replaced by the direction bit.
- R6: On success the received byte is loaded into the data register (address 4), and status bit 1 (done) is set. A claim read then returns 0x02, and later peeks return 0x42.
- R7: If the slave does not acknowledge any of the three transmitted bytes, status bit 2 is set and a STOP is issued. No further byte is sent, busy clears, and the data register keeps its old value.
- R8: If the data line is sampled low while the host is releasing it during a transmitted data bit, status bit 3 is set. The host then releases both lines at once without a STOP, and busy clears.
- R9: A start word whose protocol code is not 010 sets status bit 4 and causes no bus activity. The protocol field reads back in bits 4:2 of the control register, and bit 6 always reads 0.
- R10: While busy, writes to the control, command and address registers are ignored, so a second start word does not restart the transfer.
- R11: The data register can be written and read back by software at any time before a transfer.
- R12: The bus quarter period is QDIV clocks. Every SCL high pulse inside a transfer lasts 2*QDIV clocks, and SCL and SDA change only on quarter ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (needed for the status claim side effect) |
| reg_addr | input | 3 | Register select: 0 status, 1 control, 2 command, 3 address, 4 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| scl_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Level of the SDA line |

## Verification
The assertions check several properties on every cycle. The quarter tick never fires on two cycles in a row. The bus lines move only on ticks. A bus error leaves both lines released on the next cycle. At most one of the completion, no-acknowledge and collision events fires at a time. Busy rises only after a start write. The done flag rises only as busy falls. A status claim sets ownership. The command register holds while busy.

Some behaviours can only be shown by the bench's scenarios, which run against a slave model. These are the bit order and byte contents on the wire and the repeated START between the write and read phases. They also include where each no-acknowledge stops the transfer, the data byte landing in the data register, and the exact status words seen by software.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_START,
    SQ_TX,
    SQ_RSTART,
    SQ_RX,
    SQ_STOP
  } seq_state_t;

  localparam int          RAW         = 3;
  localparam logic [RAW-1:0] A_STAT   = 3'd0;
  localparam logic [RAW-1:0] A_CTL    = 3'd1;
  localparam logic [RAW-1:0] A_CMD    = 3'd2;
  localparam logic [RAW-1:0] A_ADDR   = 3'd3;
  localparam logic [RAW-1:0] A_DATA   = 3'd4;

  localparam int ST_BUSY  = 0;
  localparam int ST_DONE  = 1;
  localparam int ST_DERR  = 2;
  localparam int ST_BERR  = 3;
  localparam int ST_FAIL  = 4;
  localparam int ST_INUSE = 6;

  localparam int         CTL_GO     = 6;
  localparam logic [2:0] PROTO_BDR  = 3'b010;

endpackage

// File: rtl/smb_qtick.sv
module smb_qtick #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          wrap;

  assign wrap = (cnt_q == LAST);
  assign tick = run && wrap;

  always_comb begin
    cnt_n = cnt_q;
    if (!run)      cnt_n = '0;
    else if (wrap) cnt_n = '0;
    else           cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // R12
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/smb_byteread_seq.sv
module smb_byteread_seq
  import smb_host_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       tick,
  input  logic       sda_in,
  input  logic [6:0] slv_addr,
  input  logic [7:0] cmd_byte,
  output logic       busy,
  output logic       scl_low,
  output logic       sda_low,
  output logic       ev_done,
  output logic       ev_nack,
  output logic       ev_berr,
  output logic [7:0] rx_byte
);
  seq_state_t state_q, state_n;
  logic [1:0] q_q, q_n;
  logic [3:0] bit_q, bit_n;
  logic [1:0] byte_q, byte_n;
  logic [7:0] sh_q, sh_n;
  logic       nak_q, nak_n;
  logic       samp, last, data_bit;

  assign samp     = tick && (q_q == 2'd2);
  assign last     = tick && (q_q == 2'd3);
  assign data_bit = (bit_q < 4'd8);

  always_comb begin
    state_n = state_q;
    q_n     = q_q;
    bit_n   = bit_q;
    byte_n  = byte_q;
    sh_n    = sh_q;
    nak_n   = nak_q;
    ev_done = 1'b0;
    ev_nack = 1'b0;
    ev_berr = 1'b0;
    if (state_q == SQ_IDLE) begin
      if (start) begin
        state_n = SQ_START;
        q_n     = 2'd0;
        byte_n  = 2'd0;
        nak_n   = 1'b0;
      end
    end else begin
      if (tick) q_n = q_q + 2'd1;
      unique case (state_q)
        SQ_START: if (last) begin
          state_n = SQ_TX;
          bit_n   = 4'd0;
          sh_n    = {slv_addr, 1'b0};
        end
        SQ_TX: begin
          if (samp && data_bit && sh_q[7] && !sda_in) begin
            state_n = SQ_IDLE;
            ev_berr = 1'b1;
          end
          if (samp && !data_bit && sda_in) nak_n = 1'b1;
          if (last) begin
            if (data_bit) begin
              bit_n = bit_q + 4'd1;
              sh_n  = {sh_q[6:0], 1'b0};
            end else if (nak_q) begin
              state_n = SQ_STOP;
            end else if (byte_q == 2'd0) begin
              byte_n = 2'd1;
              bit_n  = 4'd0;
              sh_n   = cmd_byte;
            end else if (byte_q == 2'd1) begin
              state_n = SQ_RSTART;
            end else begin
              state_n = SQ_RX;
              bit_n   = 4'd0;
            end
          end
        end
        SQ_RSTART: if (last) begin
          state_n = SQ_TX;
          byte_n  = 2'd2;
          bit_n   = 4'd0;
          sh_n    = {slv_addr, 1'b1};
        end
        SQ_RX: begin
          if (samp && data_bit) sh_n = {sh_q[6:0], sda_in};
          if (last) begin
            if (data_bit) bit_n = bit_q + 4'd1;
            else          state_n = SQ_STOP;
          end
        end
        SQ_STOP: if (last) begin
          state_n = SQ_IDLE;
          ev_done = !nak_q;
          ev_nack = nak_q;
        end
        default: state_n = SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    scl_low = 1'b0;
    sda_low = 1'b0;
    unique case (state_q)
      SQ_START: begin
        scl_low = (q_q == 2'd3);
        sda_low = (q_q != 2'd0);
      end
      SQ_RSTART: begin
        scl_low = (q_q == 2'd0) || (q_q == 2'd3);
        sda_low = (q_q >= 2'd2);
      end
      SQ_TX: begin
        scl_low = (q_q == 2'd0) || (q_q == 2'd3);
        sda_low = data_bit && !sh_q[7];
      end
      SQ_RX:   scl_low = (q_q == 2'd0) || (q_q == 2'd3);
      SQ_STOP: begin
        scl_low = (q_q == 2'd0);
        sda_low = (q_q < 2'd2);
      end
      default: ;
    endcase
  end

  assign busy    = (state_q != SQ_IDLE);
  assign rx_byte = sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      q_q     <= 2'd0;
      bit_q   <= 4'd0;
      byte_q  <= 2'd0;
      sh_q    <= 8'd0;
      nak_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      q_q     <= q_n;
      bit_q   <= bit_n;
      byte_q  <= byte_n;
      sh_q    <= sh_n;
      nak_q   <= nak_n;
    end
  end

  // R12
  scl_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(scl_low));
  // R12
  sda_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sda_low));
  // R8
  berr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_berr |=> (!scl_low && !sda_low));
  // R7
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_done, ev_nack, ev_berr}));

endmodule

// File: rtl/smb_host.sv
module smb_host
  import smb_host_pkg::*;
#(
  parameter int QDIV = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic       reg_re,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       scl_low,
  output logic       sda_low,
  input  logic       sda_i
);
  logic       sda_s1_q, sda_s2_q;
  logic [7:0] addr_q, addr_n, cmd_q, cmd_n, data_q, data_n;
  logic [2:0] proto_q, proto_n;
  logic       done_q, done_n, derr_q, derr_n, berr_q, berr_n;
  logic       fail_q, fail_n, inuse_q, inuse_n;
  logic       busy, tick, go_ok, go_bad;
  logic       ev_done, ev_nack, ev_berr;
  logic [7:0] rx_byte;
  logic       wr_stat, wr_ctl, wr_cmd, wr_addr, wr_data, rd_stat;

  assign wr_stat = reg_we && (reg_addr == A_STAT);
  assign wr_ctl  = reg_we && (reg_addr == A_CTL) && !busy;
  assign wr_cmd  = reg_we && (reg_addr == A_CMD) && !busy;
  assign wr_addr = reg_we && (reg_addr == A_ADDR) && !busy;
  assign wr_data = reg_we && (reg_addr == A_DATA);
  assign rd_stat = reg_re && (reg_addr == A_STAT);
  assign go_ok   = wr_ctl && reg_wdata[CTL_GO] && (reg_wdata[4:2] == PROTO_BDR);
  assign go_bad  = wr_ctl && reg_wdata[CTL_GO] && (reg_wdata[4:2] != PROTO_BDR);

  smb_qtick #(.DIV(QDIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .tick (tick)
  );

  smb_byteread_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (go_ok),
    .tick    (tick),
    .sda_in  (sda_s2_q),
    .slv_addr(addr_q[7:1]),
    .cmd_byte(cmd_q),
    .busy    (busy),
    .scl_low (scl_low),
    .sda_low (sda_low),
    .ev_done (ev_done),
    .ev_nack (ev_nack),
    .ev_berr (ev_berr),
    .rx_byte (rx_byte)
  );

  always_comb begin
    done_n  = ev_done || (done_q && !(wr_stat && reg_wdata[ST_DONE]));
    derr_n  = ev_nack || (derr_q && !(wr_stat && reg_wdata[ST_DERR]));
    berr_n  = ev_berr || (berr_q && !(wr_stat && reg_wdata[ST_BERR]));
    fail_n  = go_bad  || (fail_q && !(wr_stat && reg_wdata[ST_FAIL]));
    inuse_n = inuse_q;
    if (wr_stat && reg_wdata[ST_INUSE]) inuse_n = 1'b0;
    else if (rd_stat)                   inuse_n = 1'b1;
    addr_n  = wr_addr ? reg_wdata : addr_q;
    cmd_n   = wr_cmd  ? reg_wdata : cmd_q;
    proto_n = wr_ctl  ? reg_wdata[4:2] : proto_q;
    data_n  = data_q;
    if (ev_done)      data_n = rx_byte;
    else if (wr_data) data_n = reg_wdata;
  end

  always_comb begin
    unique case (reg_addr)
      A_STAT:  reg_rdata = {1'b0, inuse_q, 1'b0, fail_q, berr_q, derr_q, done_q, busy};
      A_CTL:   reg_rdata = {3'b000, proto_q, 2'b00};
      A_CMD:   reg_rdata = cmd_q;
      A_ADDR:  reg_rdata = addr_q;
      A_DATA:  reg_rdata = data_q;
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_s1_q <= 1'b1;
      sda_s2_q <= 1'b1;
      addr_q   <= 8'h00;
      cmd_q    <= 8'h00;
      data_q   <= 8'h00;
      proto_q  <= 3'd0;
      done_q   <= 1'b0;
      derr_q   <= 1'b0;
      berr_q   <= 1'b0;
      fail_q   <= 1'b0;
      inuse_q  <= 1'b0;
    end else begin
      sda_s1_q <= sda_i;
      sda_s2_q <= sda_s1_q;
      addr_q   <= addr_n;
      cmd_q    <= cmd_n;
      data_q   <= data_n;
      proto_q  <= proto_n;
      done_q   <= done_n;
      derr_q   <= derr_n;
      berr_q   <= berr_n;
      fail_q   <= fail_n;
      inuse_q  <= inuse_n;
    end
  end

  // R2
  claim_sets_inuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !(wr_stat && reg_wdata[ST_INUSE])) |=> inuse_q);
  // R10
  cmd_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && (reg_addr == A_CMD)) |=> $stable(cmd_q));
  // R4
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_we && (reg_addr == A_CTL) && reg_wdata[CTL_GO]));
  // R6
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> (!busy && $past(busy)));

endmodule

// File: tb/tb_smb_host.sv
`timescale 1ns/1ps
module tb_smb_host;
  localparam int CLK_PERIOD = 10;
  localparam int QDIV       = 4;

  logic       clk, rst_n, reg_we, reg_re;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       scl_low, sda_low, sda_i;

  logic       sl_low, jam, sl_clr;
  logic [7:0] reply;
  int         nack_at;
  logic       bus_scl, bus_sda, p_scl, p_sda;
  int         cnt, nb, n_start, n_stop, bad_hi, hi_start, cyc;
  logic       rd_mode, hi_valid, mack;
  logic [7:0] sh, seen [4];

  int checks, fails;
  bit finished;

  assign bus_scl = ~scl_low;
  assign bus_sda = ~(sda_low | sl_low | jam);
  assign sda_i   = bus_sda;

  smb_host #(.QDIV(QDIV)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .scl_low(scl_low), .sda_low(sda_low), .sda_i(sda_i)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Slave model: acks bytes except index nack_at, returns reply after addr+R.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n || sl_clr) begin
      p_scl <= 1'b1; p_sda <= 1'b1; cnt <= 0; nb <= 0; n_start <= 0; n_stop <= 0;
      bad_hi <= 0; rd_mode <= 1'b0; hi_valid <= 1'b0; mack <= 1'b0; sl_low <= 1'b0;
      sh <= 8'h00;
      for (int i = 0; i < 4; i++) seen[i] <= 8'hEE;
    end else begin
      p_scl <= bus_scl;
      p_sda <= bus_sda;
      if (p_scl && bus_scl && p_sda && !bus_sda) begin
        n_start <= n_start + 1; cnt <= 0; rd_mode <= 1'b0; sl_low <= 1'b0; hi_valid <= 1'b0;
      end else if (p_scl && bus_scl && !p_sda && bus_sda) begin
        n_stop <= n_stop + 1;
      end else if (!p_scl && bus_scl) begin
        hi_start <= cyc; hi_valid <= 1'b1;
        if (cnt < 8 && !rd_mode) sh <= {sh[6:0], bus_sda};
        if (cnt == 8 && rd_mode) mack <= bus_sda;
        cnt <= cnt + 1;
      end else if (p_scl && !bus_scl) begin
        if (hi_valid && (cyc - hi_start) != 2*QDIV) bad_hi <= bad_hi + 1;
        hi_valid <= 1'b0;
        if (cnt == 8) begin
          if (!rd_mode) begin
            if (nb < 4) seen[nb] <= sh;
            sl_low <= (nb != nack_at);
          end else sl_low <= 1'b0;
        end else if (cnt == 9) begin
          cnt <= 0;
          if (!rd_mode) nb <= nb + 1;
          if (!rd_mode && nb == 2 && nack_at != 2) begin
            rd_mode <= 1'b1; sl_low <= ~reply[7];
          end else sl_low <= 1'b0;
        end else if (rd_mode && cnt >= 1 && cnt <= 7) begin
          sl_low <= ~reply[7-cnt];
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic claim(output logic [7:0] d);
    @(negedge clk); reg_re = 1'b1; reg_addr = 3'd0; #1 d = reg_rdata;
    @(negedge clk); reg_re = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic clr_slave();
    @(negedge clk); sl_clr = 1'b1;
    @(negedge clk); sl_clr = 1'b0;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 4000; i++) begin
      peek(3'd0, s);
      if (!s[0]) break;
    end
  endtask

  task automatic run_xact(input logic [6:0] a, input logic [7:0] c, input logic [7:0] r,
                          input int nk, input bit jm, input bit poke);
    logic [7:0] s, e [3];
    int last_b, exp_start, exp_stat;
    e[0] = {a, 1'b0}; e[1] = c; e[2] = {a, 1'b1};
    reply = r; nack_at = nk; jam = jm;
    clr_slave();
    wr(3'd0, 8'hFE);
    wr(3'd4, 8'h5A);
    wr(3'd3, {a, 1'b1});
    wr(3'd2, c);
    wr(3'd1, 8'h48);
    peek(3'd0, s);
    check("R4 busy after start", s[0], 1);
    if (poke) begin
      wr(3'd2, ~c);
      wr(3'd3, 8'h00);
      wr(3'd1, 8'h48);
    end
    wait_idle();
    claim(s);
    exp_stat = jm ? 8'h08 : (nk < 3) ? 8'h04 : 8'h02;
    check(jm ? "R8 status" : (nk < 3) ? "R7 status" : "R6 status claim", s, exp_stat);
    peek(3'd0, s);
    check("R2 in use after claim", s, exp_stat | 8'h40);
    peek(3'd4, s);
    check(jm || nk < 3 ? "R7 data kept" : "R6 data", s, (jm || nk < 3) ? 8'h5A : r);
    if (jm) begin
      check("R8 no stop", n_stop, 0);
      check("R8 lines released", {scl_low, sda_low}, 0);
    end else begin
      last_b = (nk < 3) ? nk : 2;
      for (int i = 0; i <= last_b; i++) check("R5 byte on wire", seen[i], e[i]);
      exp_start = (nk < 2) ? 1 : 2;
      check("R5 start count", n_start, exp_start);
      check("R7 stop issued", n_stop, 1);
      check("R12 scl high width", bad_hi, 0);
      if (nk == 3) check("R5 master nack", mack, 1);
      if (poke) begin
        peek(3'd2, s);
        check("R10 command held", s, c);
        peek(3'd3, s);
        check("R10 address held", s, {a, 1'b1});
      end
    end
    jam = 1'b0;
  endtask

  initial begin
    logic [7:0] s, r;
    checks = 0; fails = 0; finished = 0;
    rst_n = 1'b0; reg_we = 1'b0; reg_re = 1'b0; reg_addr = 3'd0; reg_wdata = 8'h00;
    jam = 1'b0; sl_clr = 1'b0; reply = 8'h00; nack_at = 3; cyc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 5; a++) begin
      peek(a[2:0], s);
      check("R1 reset register", s, 0);
    end
    check("R1 lines released", {scl_low, sda_low}, 0);

    wr(3'd4, 8'hA5);
    peek(3'd4, s);
    check("R11 data readback", s, 8'hA5);

    peek(3'd0, s);
    peek(3'd0, s);
    check("R2 peek does not claim", s[6], 0);
    claim(s);
    check("R2 claim returns old", s[6], 0);
    claim(s);
    check("R2 second claim sees owned", s[6], 1);

    for (int k = 0; k < 8; k++) begin
      r = (k == 0) ? 8'h00 : (k == 7) ? 8'hFF : 8'((k * 53 + 17) & 8'hFF);
      run_xact(7'((8'h50 + k * 5) & 8'h7F), 8'((k * 37 + 3) & 8'hFF), r, 3, 1'b0, k == 3);
    end
    for (int n = 0; n < 3; n++) run_xact(7'h2C + 7'(n), 8'h10 + 8'(n), 8'h77, n, 1'b0, 1'b0);

    peek(3'd0, s);
    check("R7 status before clear", s, 8'h44);
    wr(3'd0, 8'h02);
    peek(3'd0, s);
    check("R3 unrelated bit write", s, 8'h44);
    wr(3'd0, 8'h04);
    peek(3'd0, s);
    check("R3 w1c device error", s, 8'h40);
    wr(3'd0, 8'h40);
    peek(3'd0, s);
    check("R3 release ownership", s, 8'h00);

    run_xact(7'h50, 8'h00, 8'h33, 3, 1'b1, 1'b0);
    wr(3'd0, 8'hFE);
    peek(3'd0, s);
    check("R3 host reset pattern", s, 8'h00);

    clr_slave();
    wr(3'd1, 8'h44);
    peek(3'd0, s);
    check("R9 failed flag", s, 8'h10);
    repeat (40) @(negedge clk);
    check("R9 no bus activity", n_start, 0);
    peek(3'd1, s);
    check("R9 control readback", s, 8'h04);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule